// File: doc/BRIEF.md
# Power-Good Status Aggregator

This block merges the regulation status of six supply channels into a single active-low power-good indication. The indication is meant to drive an open-drain pin, and it has three states. In the first the pin is pulled low. In the second the pin is released and the external pull-up reads as good. In the third the pin floats because the monitor has no backup power. Each channel supplies an enable bit and a digitised in-regulation flag. The regulation window itself is set by the comparators upstream.

Several qualifications apply before a fault counts. A disabled channel is ignored. Channel 3 is ignored while its voltage slews to a newly programmed level, and for one cycle after the slew flag drops. A channel that has just been switched on forces the pin low until it reports in regulation. Some conditions override the channel check entirely: the pin is held low when no channel is enabled or during undervoltage lockout. The pin floats when backup power is absent. A seventh, always-on channel reports status on its own pin, but that pin is not monitored.

The regulation flags are asynchronous and pass through a synchroniser. The control inputs are synchronous to the clock. Both outputs come from registers.

Top module: `pwr_good_agg`

## Requirements
- R1: While `rst_n` is low, and on the first edge after release, `pg_pull_low`=1 and `pg_float`=0.
- R2: If `bkup_ok` is 0 at a clock edge, then after that edge `pg_float`=1 and `pg_pull_low`=0, whatever the other inputs are. The two outputs are never both 1.
- R3: If `bkup_ok`=1 and `uvlo`=1 at an edge, then after that edge `pg_pull_low`=1 and `pg_float`=0.
- R4: If `bkup_ok`=1, `uvlo`=0 and `ch_en`=0 at an edge, then after that edge `pg_pull_low`=1.
- R5: Bit i of `ch_en` and of `ch_ok` belongs to channel i+1. Suppose some channel is enabled, and the in-regulation flags that count are those sampled two edges before the current one. The output then pulls low if any enabled, unmasked channel reads 0, and otherwise it is released (`pg_pull_low`=0, `pg_float`=0). A change on `ch_ok` reaches the outputs on the third rising edge.
- R6: A channel whose `ch_en` bit is 0 never causes a pull-low, whatever its `ch_ok` bit is.
- R7: Channel 3 (bit 2) is masked at every edge where `ch3_slew`=1, and at the first edge after `ch3_slew` falls. A one-cycle drop in `ch3_slew` therefore creates no fault.
- R8: At the edge where an enable bit rises, and at the edge that follows, the channel counts as faulty. After that it stays faulty until its synchronised flag reads 1, and the pin is released one edge later if nothing else is wrong.
- R9: `aux_ok` (the always-on seventh channel) has no effect on either output.
- R10: `ch_en`, `ch3_slew`, `uvlo` and `bkup_ok` act on the outputs at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 6 | Channel enable bits, bit i = channel i+1 |
| ch_ok | input | 6 | Asynchronous in-regulation flags, bit i = channel i+1 |
| ch3_slew | input | 1 | Channel 3 is moving to a new programmed voltage |
| uvlo | input | 1 | Input supply is below the lockout threshold |
| bkup_ok | input | 1 | Backup supply present; 0 makes the block non-functional |
| aux_ok | input | 1 | Status of the always-on channel (unmonitored) |
| pg_pull_low | output | 1 | 1 = drive the power-good pin low |
| pg_float | output | 1 | 1 = pin floats because the monitor is unpowered |

## Verification
The assertions treat `ch_en`, `ch3_slew`, `uvlo` and `bkup_ok` as synchronous to `clk`, changing only between edges. They assume the decision made at one edge is visible at the next. The stimulus drives every input on the falling edge only. The flags on `ch_ok` may be asynchronous, but the bench also moves them on falling edges, so the two-edge synchroniser latency is exact and the per-cycle reference model can match it.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef struct packed {
    logic pull_low;
    logic float_out;
  } pg_drive_t;

  localparam pg_drive_t PG_SAFE  = '{pull_low: 1'b1, float_out: 1'b0};
  localparam pg_drive_t PG_GOOD  = '{pull_low: 1'b0, float_out: 1'b0};
  localparam pg_drive_t PG_UNPWR = '{pull_low: 1'b0, float_out: 1'b1};
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d_async;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pg_chan_qual.sv
module pg_chan_qual #(
  parameter int NCH       = 6,
  parameter int SLEW_IDX  = 2,
  parameter int SLEW_HOLD = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ok_s,
  input  logic           slew,
  output logic [NCH-1:0] fault
);
  localparam int HW = (SLEW_HOLD < 1) ? 1 : $clog2(SLEW_HOLD + 1);

  logic [NCH-1:0] en_d;
  logic [NCH-1:0] pending;
  logic [HW-1:0]  hold_cnt;
  logic           slew_mask;

  // slew mask stretched by SLEW_HOLD cycles after the flag falls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_cnt <= '0;
    else if (slew)             hold_cnt <= HW'(SLEW_HOLD);
    else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
  end
  assign slew_mask = slew || (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= '0;
    else        en_d <= ch_en;
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic rise, raw_fault;
      assign rise      = ch_en[i] && !en_d[i];
      assign raw_fault = ch_en[i] && (!ok_s[i] || pending[i] || rise);

      // turn-on hold: stays set until the synchronised flag confirms regulation
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pending[i] <= 1'b0;
        else if (!ch_en[i])         pending[i] <= 1'b0;
        else if (rise)              pending[i] <= 1'b1;
        else if (ok_s[i])           pending[i] <= 1'b0;
      end

      if (i == SLEW_IDX) begin : g_slew
        assign fault[i] = raw_fault && !slew_mask;
      end else begin : g_plain
        assign fault[i] = raw_fault;
      end
    end
  endgenerate
endmodule

// File: rtl/pg_resolve.sv
module pg_resolve
  import pg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bkup_ok,
  input  logic      uvlo,
  input  logic      any_en,
  input  logic      any_fault,
  output pg_drive_t drv
);
  pg_drive_t nxt;

  always_comb begin
    if (!bkup_ok)       nxt = PG_UNPWR;
    else if (uvlo)      nxt = PG_SAFE;
    else if (!any_en)   nxt = PG_SAFE;
    else if (any_fault) nxt = PG_SAFE;
    else                nxt = PG_GOOD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv <= PG_SAFE;
    else        drv <= nxt;
  end
endmodule

// File: rtl/pwr_good_agg.sv
module pwr_good_agg
  import pg_pkg::*;
#(
  parameter int NCH         = 6,
  parameter int SLEW_IDX    = 2,
  parameter int SLEW_HOLD   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_ok,
  input  logic           ch3_slew,
  input  logic           uvlo,
  input  logic           bkup_ok,
  input  logic           aux_ok,
  output logic           pg_pull_low,
  output logic           pg_float
);
  logic [NCH-1:0] ok_s;
  logic [NCH-1:0] fault;
  pg_drive_t      drv;
  logic           unused_aux;

  assign unused_aux = aux_ok;

  pg_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ch_ok), .q_sync(ok_s)
  );

  pg_chan_qual #(.NCH(NCH), .SLEW_IDX(SLEW_IDX), .SLEW_HOLD(SLEW_HOLD)) u_qual (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ok_s(ok_s),
    .slew(ch3_slew), .fault(fault)
  );

  pg_resolve u_res (
    .clk(clk), .rst_n(rst_n), .bkup_ok(bkup_ok), .uvlo(uvlo),
    .any_en(|ch_en), .any_fault(|fault), .drv(drv)
  );

  assign pg_pull_low = drv.pull_low;
  assign pg_float    = drv.float_out;
endmodule

// File: rtl/pg_agg_chk.sv
module pg_agg_chk #(
  parameter int NCH = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_en,
  input logic           uvlo,
  input logic           bkup_ok,
  input logic           pg_pull_low,
  input logic           pg_float
);
  logic [NCH-1:0] en_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= '0;
    else        en_prev <= ch_en;
  end

  assert_unpowered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bkup_ok |=> (pg_float && !pg_pull_low));

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_float && pg_pull_low));

  assert_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bkup_ok && uvlo) |=> (pg_pull_low && !pg_float));

  assert_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bkup_ok && ch_en == '0) |=> pg_pull_low);

  assert_turn_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bkup_ok && (ch_en & ~en_prev) != '0) |=> pg_pull_low);
endmodule

bind pwr_good_agg pg_agg_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .uvlo(uvlo), .bkup_ok(bkup_ok),
  .pg_pull_low(pg_pull_low), .pg_float(pg_float)
);

// File: tb/pwr_good_agg_tb.sv
`timescale 1ns/1ps
module pwr_good_agg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ch_en = '0, ch_ok = '0;
  logic ch3_slew = 0, uvlo = 0, bkup_ok = 1, aux_ok = 0;
  logic pg_pull_low, pg_float;

  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  pwr_good_agg u_dut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_ok(ch_ok), .ch3_slew(ch3_slew),
    .uvlo(uvlo), .bkup_ok(bkup_ok), .aux_ok(aux_ok),
    .pg_pull_low(pg_pull_low), .pg_float(pg_float)
  );

  // behavioural reference, evaluated at each rising edge
  logic [5:0] hist[$];
  logic [5:0] m_en_prev, m_pend;
  int m_hold;
  logic e_low = 1, e_float = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{6'd0, 6'd0};
      m_en_prev = 0; m_pend = 0; m_hold = 0;
      e_low = 1; e_float = 0;
    end else begin
      logic [5:0] oks;
      logic masked, anyf;
      oks = hist[0];
      masked = ch3_slew || (m_hold > 0);
      anyf = 0;
      for (int i = 0; i < 6; i++) begin
        bit f;
        f = ch_en[i] && (!oks[i] || m_pend[i] || !m_en_prev[i]);
        if (i == 2 && masked) f = 0;
        if (f) anyf = 1;
      end
      if (!bkup_ok)          begin e_low = 0; e_float = 1; end
      else if (uvlo)         begin e_low = 1; e_float = 0; end
      else if (ch_en == 0)   begin e_low = 1; e_float = 0; end
      else                   begin e_low = anyf; e_float = 0; end
      for (int i = 0; i < 6; i++) begin
        if (!ch_en[i]) m_pend[i] = 0;
        else if (!m_en_prev[i]) m_pend[i] = 1;
        else if (oks[i]) m_pend[i] = 0;
      end
      m_hold = ch3_slew ? 1 : ((m_hold > 0) ? m_hold - 1 : 0);
      m_en_prev = ch_en;
      hist.push_back(ch_ok);
      void'(hist.pop_front());
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    cyc++;
    total++;
    if (pg_pull_low !== e_low || pg_float !== e_float) begin
      bad++;
      $display("FAIL %s cyc=%0d actual low=%b float=%b expected low=%b float=%b",
               tag, cyc, pg_pull_low, pg_float, e_low, e_float);
    end
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string t, logic act_low, logic act_fl, logic ex_low, logic ex_fl);
    total++;
    if (act_low !== ex_low || act_fl !== ex_fl) begin
      bad++;
      $display("FAIL %s actual low=%b float=%b expected low=%b float=%b",
               t, act_low, act_fl, ex_low, ex_fl);
    end
  endtask

  logic [7:0] lfsr = 8'hA5;

  initial begin
    // R1: reset state
    step(4);
    check("R1", pg_pull_low, pg_float, 1, 0);
    rst_n = 1;
    step(1);
    check("R1", pg_pull_low, pg_float, 1, 0);
    // R4: every channel off
    tag = "R4"; step(4);
    check("R4", pg_pull_low, pg_float, 1, 0);
    // R8 then R5: enable all with good flags
    tag = "R8"; ch_ok = 6'h3F; ch_en = 6'h3F; step(2);
    check("R8", pg_pull_low, pg_float, 1, 0);
    tag = "R5"; step(4);
    check("R5", pg_pull_low, pg_float, 0, 0);
    // R5: channel 1 out of regulation
    ch_ok[0] = 0; step(2);
    check("R5", pg_pull_low, pg_float, 0, 0);
    step(1);
    check("R5", pg_pull_low, pg_float, 1, 0);
    ch_ok[0] = 1; step(4);
    check("R5", pg_pull_low, pg_float, 0, 0);
    // R6: disabled channel ignored
    tag = "R6"; ch_en[1] = 0; step(1); ch_ok[1] = 0; step(5);
    check("R6", pg_pull_low, pg_float, 0, 0);
    // R8: re-enable with bad flag stays low until flag good
    tag = "R8"; ch_en[1] = 1; step(4);
    check("R8", pg_pull_low, pg_float, 1, 0);
    ch_ok[1] = 1; step(5);
    check("R8", pg_pull_low, pg_float, 0, 0);
    // R7: channel 3 masked during slew and one cycle after, glitch tolerant
    tag = "R7"; ch3_slew = 1; ch_ok[2] = 0; step(4);
    check("R7", pg_pull_low, pg_float, 0, 0);
    ch3_slew = 0; step(1); ch3_slew = 1; step(3);
    check("R7", pg_pull_low, pg_float, 0, 0);
    ch3_slew = 0; step(1);
    check("R7", pg_pull_low, pg_float, 0, 0);
    step(1);
    check("R7", pg_pull_low, pg_float, 1, 0);
    ch_ok[2] = 1; step(4);
    // R9: always-on channel toggling has no effect
    tag = "R9";
    for (int k = 0; k < 8; k++) begin
      aux_ok = ~aux_ok; step(1);
      check("R9", pg_pull_low, pg_float, 0, 0);
    end
    // R3 and R2: forced states and their priority
    tag = "R3"; uvlo = 1; step(1);
    check("R3", pg_pull_low, pg_float, 1, 0);
    tag = "R2"; bkup_ok = 0; step(1);
    check("R2", pg_pull_low, pg_float, 0, 1);
    uvlo = 0; ch_en = 0; step(2);
    check("R2", pg_pull_low, pg_float, 0, 1);
    bkup_ok = 1; ch_en = 6'h3F; step(6);
    // R10: mixed pseudo-random activity, compared every cycle
    tag = "R10";
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ch_ok    = {lfsr[2:0], lfsr[7:5]} | 6'h24;
      if (lfsr[1:0] == 0) ch_en = lfsr[7:2];
      ch3_slew = lfsr[4] & lfsr[6];
      uvlo     = (lfsr == 8'h11);
      bkup_ok  = (lfsr[7:3] != 5'h1F);
      aux_ok   = lfsr[0];
      step(1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule